// File: doc/BRIEF.md
# Second-Level Event Buffer Occupancy Controller

This block keeps track of how many events are waiting in the second-level event buffer of a front-end board. A first-level accept writes one event, and the block adds it to its count. Second-level decisions arrive later, each with a valid strobe and an accept/reject bit. They are applied to stored events strictly oldest first. An accepted event produces a one-cycle read request. A rejected event produces a one-cycle discard pulse. Either outcome removes the event from the count. The data words themselves (four tags and thirty-two samples per event) are stored and read out by other logic.

Two protections sit around the count. First, when the downstream derandomizer reports that it is nearly full, an accept is turned into a discard so that the output stage cannot overflow. Second, a throttle output tells first-level triggering to hold off. It rises once occupancy reaches a high-water mark and stays raised until occupancy falls below a lower mark, so it does not chatter near a single threshold. Misuse is reported at the ports. A write into a full buffer is dropped and sets a sticky overflow flag. A decision with no stored event raises a one-cycle sequence-error pulse.

Top module: `l2occ_monitor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `evt_count` is 0 and `throttle`, `read_req`, `discard`, `seq_err` and `overflow` are all 0.
- R2: A cycle with `l0_write`=1 and a count below DEPTH (and no decision) raises `evt_count` by one, visible after the next clock edge.
- R3: A write seen while the count equals DEPTH leaves the count unchanged and sets `overflow`. Once set, `overflow` stays 1 until reset.
- R4: A decision (`dec_valid`=1, `dec_accept`=1) with at least one stored event and `derand_full`=0 gives `read_req`=1 for exactly one cycle after the edge, and the count falls by one.
- R5: An accept decision made while `derand_full`=1 gives `discard`=1 instead of `read_req`, and the count falls by one.
- R6: A reject decision (`dec_accept`=0) with a stored event gives `discard`=1 for one cycle, whatever `derand_full` is, and the count falls by one.
- R7: A decision made while the count is 0 gives `seq_err`=1 for one cycle. It produces no `read_req` and no `discard`, and it does not lower the count.
- R8: A write and a decision in the same cycle, with the count between 1 and DEPTH-1, leave the count unchanged.
- R9: `throttle` is 1 in every cycle in which `evt_count` is at least THR_HIGH.
- R10: `throttle` is 0 in every cycle in which `evt_count` is below THR_LOW. Between the two marks it keeps its previous value.
- R11: `read_req` and `discard` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l0_write | input | 1 | A first-level accept writes one event |
| dec_valid | input | 1 | A second-level decision is present this cycle |
| dec_accept | input | 1 | 1 = accept, 0 = reject (read only while dec_valid=1) |
| derand_full | input | 1 | Downstream derandomizer is nearly full |
| evt_count | output | $clog2(DEPTH+1) | Number of events stored |
| throttle | output | 1 | Hold off first-level triggers |
| read_req | output | 1 | One-cycle request to read out the oldest event |
| discard | output | 1 | One-cycle pulse to drop the oldest event |
| seq_err | output | 1 | One-cycle pulse: decision arrived with no stored event |
| overflow | output | 1 | Sticky flag: a write hit a full buffer |

## Verification
The bench runs a small configuration (depth 20, marks 16 and 12) through whole fill and drain sweeps. The write-only fill past depth separates normal increments from dropped writes and the sticky overflow flag. The drain applies every combination of accept bit and derandomizer state, one decision every other cycle. This separates a read request from a plain reject and from a forced discard. Decisions on an empty buffer, writes paired with decisions at empty, middle and full counts, and repeated crossings of the two throttle marks show that the sequence check, the net-zero update and the hysteresis act apart from each other.

// File: rtl/l2occ_pkg.sv
package l2occ_pkg;

   typedef enum logic [1:0] {
      OUT_NONE   = 2'd0,
      OUT_READ   = 2'd1,
      OUT_DROP   = 2'd2,
      OUT_SEQERR = 2'd3
   } dec_outcome_e;

endpackage

// File: rtl/l2occ_decide.sv
module l2occ_decide
   import l2occ_pkg::*;
#(
   parameter bit NF_FORCES_REJECT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dec_valid,
   input  logic dec_accept,
   input  logic derand_full,
   input  logic have_event,
   output logic pop,
   output logic read_req,
   output logic discard,
   output logic seq_err
);

   logic         acc_eff;
   dec_outcome_e outcome;

   generate
      if (NF_FORCES_REJECT) begin : g_force
         assign acc_eff = dec_accept & ~derand_full;
      end else begin : g_plain
         logic unused_nf;
         assign unused_nf = derand_full;
         assign acc_eff   = dec_accept;
      end
   endgenerate

   always_comb begin
      outcome = OUT_NONE;
      if (dec_valid) begin
         if (!have_event)  outcome = OUT_SEQERR;
         else if (acc_eff) outcome = OUT_READ;
         else              outcome = OUT_DROP;
      end
   end

   assign pop = (outcome == OUT_READ) || (outcome == OUT_DROP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         read_req <= 1'b0;
         discard  <= 1'b0;
         seq_err  <= 1'b0;
      end else begin
         read_req <= (outcome == OUT_READ);
         discard  <= (outcome == OUT_DROP);
         seq_err  <= (outcome == OUT_SEQERR);
      end
   end

   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(read_req && discard));

   p_seqerr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |-> (!read_req && !discard));

   p_empty_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !have_event) |=> seq_err);

endmodule

// File: rtl/l2occ_count.sv
module l2occ_count #(
   parameter int DEPTH = 1000,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             pop,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_next,
   output logic             overflow
);

   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

   logic full;
   logic wr_ok;

   assign full  = (cnt == FULL_C);
   assign wr_ok = wr & ~full;

   always_comb begin
      unique case ({wr_ok, pop})
         2'b10:   cnt_next = cnt + 1'b1;
         2'b01:   cnt_next = cnt - 1'b1;
         default: cnt_next = cnt;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         overflow <= 1'b0;
      end else begin
         cnt      <= cnt_next;
         overflow <= overflow | (wr & full);
      end
   end

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL_C);

   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !full && !pop) |=> (cnt == $past(cnt) + 1'b1));

   p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full && !pop) |=> (cnt == FULL_C) && overflow);

endmodule

// File: rtl/l2occ_throttle.sv
module l2occ_throttle #(
   parameter int CNT_W    = 10,
   parameter int THR_HIGH = 960,
   parameter int THR_LOW  = 900
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cnt_next,
   output logic             throttle
);

   localparam logic [CNT_W-1:0] HI_C = CNT_W'(THR_HIGH);
   localparam logic [CNT_W-1:0] LO_C = CNT_W'(THR_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  throttle <= 1'b0;
      else if (cnt_next >= HI_C)   throttle <= 1'b1;
      else if (cnt_next <  LO_C)   throttle <= 1'b0;
   end

   p_thr_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >= HI_C) |-> throttle);

   p_thr_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt < LO_C) |-> !throttle);

   p_thr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >= LO_C && cnt < HI_C && $past(cnt) >= LO_C && $past(cnt) < HI_C)
         |-> $stable(throttle));

endmodule

// File: rtl/l2occ_monitor.sv
module l2occ_monitor #(
   parameter int DEPTH            = 1000,
   parameter int THR_HIGH         = 960,
   parameter int THR_LOW          = 900,
   parameter bit NF_FORCES_REJECT = 1'b1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l0_write,
   input  logic             dec_valid,
   input  logic             dec_accept,
   input  logic             derand_full,
   output logic [CNT_W-1:0] evt_count,
   output logic             throttle,
   output logic             read_req,
   output logic             discard,
   output logic             seq_err,
   output logic             overflow
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("l2occ_monitor: DEPTH must be at least 2");
      end
      if (!(THR_LOW > 0 && THR_LOW < THR_HIGH && THR_HIGH <= DEPTH)) begin : g_bad_marks
         $error("l2occ_monitor: need 0 < THR_LOW < THR_HIGH <= DEPTH");
      end
   endgenerate

   logic             pop;
   logic [CNT_W-1:0] cnt_next;

   l2occ_decide #(
      .NF_FORCES_REJECT (NF_FORCES_REJECT)
   ) u_decide (
      .clk         (clk),
      .rst_n       (rst_n),
      .dec_valid   (dec_valid),
      .dec_accept  (dec_accept),
      .derand_full (derand_full),
      .have_event  (evt_count != '0),
      .pop         (pop),
      .read_req    (read_req),
      .discard     (discard),
      .seq_err     (seq_err)
   );

   l2occ_count #(
      .DEPTH (DEPTH)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (l0_write),
      .pop      (pop),
      .cnt      (evt_count),
      .cnt_next (cnt_next),
      .overflow (overflow)
   );

   l2occ_throttle #(
      .CNT_W    (CNT_W),
      .THR_HIGH (THR_HIGH),
      .THR_LOW  (THR_LOW)
   ) u_throttle (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (evt_count),
      .cnt_next (cnt_next),
      .throttle (throttle)
   );

   p_net_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (l0_write && dec_valid && evt_count != '0 && evt_count != CNT_W'(DEPTH))
         |=> $stable(evt_count));

   p_pop_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (read_req || discard) |-> ($past(evt_count) != '0));

endmodule

// File: tb/l2occ_monitor_tb.sv
module l2occ_monitor_tb;

   localparam int DEPTH = 20;
   localparam int HI    = 16;
   localparam int LO    = 12;
   localparam int CW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l0_write = 1'b0, dec_valid = 1'b0, dec_accept = 1'b0, derand_full = 1'b0;
   logic [CW-1:0] evt_count;
   logic throttle, read_req, discard, seq_err, overflow;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int m_cnt = 0;
   bit m_thr = 1'b0;
   bit m_ovf = 1'b0;

   always #10 clk = ~clk;

   l2occ_monitor #(.DEPTH(DEPTH), .THR_HIGH(HI), .THR_LOW(LO)) u_dut (
      .clk(clk), .rst_n(rst_n), .l0_write(l0_write), .dec_valid(dec_valid),
      .dec_accept(dec_accept), .derand_full(derand_full), .evt_count(evt_count),
      .throttle(throttle), .read_req(read_req), .discard(discard),
      .seq_err(seq_err), .overflow(overflow));

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag, bit e_rd, bit e_dc, bit e_se);
      check(tag, "evt_count", int'(evt_count), m_cnt);
      check(tag, "throttle", int'(throttle), int'(m_thr));
      check(tag, "read_req", int'(read_req), int'(e_rd));
      check(tag, "discard", int'(discard), int'(e_dc));
      check(tag, "seq_err", int'(seq_err), int'(e_se));
      check(tag, "overflow", int'(overflow), int'(m_ovf));
      check("R11", "read_req&discard", int'(read_req & discard), 0);
   endtask

   // Inputs applied at a falling edge, outputs checked at the next falling edge.
   task automatic step(bit wr, bit dv, bit da, bit nf, string tag);
      bit have, pop, acc, e_rd, e_dc, e_se, wr_ok;
      l0_write = wr; dec_valid = dv; dec_accept = da; derand_full = nf;
      have  = (m_cnt > 0);
      pop   = dv && have;
      acc   = da && !nf;
      e_rd  = pop && acc;
      e_dc  = pop && !acc;
      e_se  = dv && !have;
      wr_ok = wr && (m_cnt < DEPTH);
      if (wr && m_cnt == DEPTH) m_ovf = 1'b1;
      m_cnt = m_cnt + int'(wr_ok) - int'(pop);
      if (m_cnt >= HI)     m_thr = 1'b1;
      else if (m_cnt < LO) m_thr = 1'b0;
      @(negedge clk);
      check_all(tag, e_rd, e_dc, e_se);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      l0_write = 0; dec_valid = 0; dec_accept = 0; derand_full = 0;
      m_cnt = 0; m_thr = 0; m_ovf = 0;
      repeat (2) @(negedge clk);
      check_all("R1", 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1", 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();

      // Fill past depth: increments, throttle rise, dropped writes.
      for (int i = 0; i < DEPTH + 3; i++)
         step(1'b1, 1'b0, 1'b0, 1'b0, (i < DEPTH) ? "R2" : "R3");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R9");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R3");

      // Drain with every accept/nearly-full pattern, spaced decisions.
      for (int i = 0; i < DEPTH; i++) begin
         case (i % 4)
            0: step(1'b0, 1'b1, 1'b1, 1'b0, "R4");
            1: step(1'b0, 1'b1, 1'b1, 1'b1, "R5");
            2: step(1'b0, 1'b1, 1'b0, 1'b0, "R6");
            default: step(1'b0, 1'b1, 1'b0, 1'b1, "R6");
         endcase
         step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
      end

      // Decisions with nothing stored.
      for (int k = 0; k < 4; k++) begin
         step(1'b0, 1'b1, k[0], k[1], "R7");
         step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
      end
      // Write and decision together at an empty buffer.
      step(1'b1, 1'b1, 1'b1, 1'b0, "R7");

      // Write and decision together in the middle range.
      for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, i[0], i[1], "R8");

      // Fill to full, then write plus decision at full.
      while (m_cnt < DEPTH) step(1'b1, 1'b0, 1'b0, 1'b0, "R9");
      step(1'b1, 1'b1, 1'b1, 1'b0, "R3");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R2");

      // Hysteresis: swing across both marks repeatedly.
      for (int r = 0; r < 3; r++) begin
         while (m_cnt >= LO - 1) begin
            step(1'b0, 1'b1, 1'b0, 1'b0, "R10");
            step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
         end
         while (m_cnt < HI - 1) step(1'b1, 1'b0, 1'b0, 1'b0, "R10");
         step(1'b0, 1'b1, 1'b1, 1'b0, "R10");
         step(1'b1, 1'b0, 1'b0, 1'b0, "R9");
         step(1'b1, 1'b0, 1'b0, 1'b0, "R9");
      end

      // Reset clears the sticky flag and the count.
      do_reset();
      step(1'b1, 1'b0, 1'b0, 1'b0, "R2");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule